// File: doc/BRIEF.md
# Data-Strobe Receive Decoder with System-Clock Resynchronizer

This block sits behind a cable port's receivers. It takes the incoming pair (encoded data on the A pair, encoded strobe on the B pair) and samples both with a fast oversampling clock. Every change in the exclusive-OR of the two lines marks one new bit, and the data level at that change is the bit's value. Bits are packed into groups whose width follows the speed code: 2, 4 or 8 bits. Each complete group crosses into the 49.152 MHz system-clock domain through a small gray-pointer FIFO and is handed to the link side with a one-cycle valid strobe.

Reception is gated. Bits are taken only while the port is enabled, the port is in its receiving state, and power-down is low. The same control inputs produce a transmit-permit output, which is low while the port receives. When the gate closes, any partial group is thrown away. The block raises sticky flags when the FIFO overflows and when the group stream stalls in the middle of a reception.

Top module: `ds_rx_resync`

## Requirements
- R1: Each change of (rx_a XOR rx_b), sampled on clk_fast, yields exactly one received bit, whose value is the level of rx_a after that change.
- R2: Speed code 0 packs 2 bits, code 1 packs 4 bits, and codes 2 and 3 pack 8 bits. A group is LSB-justified: the first bit received sits at bit position width-1, the last bit received at position 0, and unused upper bits are 0.
- R3: Groups reach grp_data on clk_sys in the order received. Each group is marked by grp_vld high for exactly one cycle, and no group is lost or repeated while the FIFO does not overflow.
- R4: Transitions on rx_a/rx_b produce no groups unless port_ok=1, port_rcv=1 and pwr_down=0.
- R5: When the receive gate closes, a partial group is discarded. The next reception starts a fresh group with its first bit.
- R6: tx_allow equals port_ok AND NOT port_rcv AND NOT pwr_down, within 3 clk_sys cycles of a change on those inputs.
- R7: A group that arrives while the 8-entry FIFO is full is dropped and sets rx_ovf. The groups already stored are still delivered in order. rx_ovf stays high until the receive gate closes, and a reception paced within the FIFO's drain rate never sets it.
- R8: Once at least one group has been delivered during a reception, GAP_MAX (32) consecutive clk_sys cycles without a group, while the gate stays open, set rx_udf. rx_udf stays high until the gate closes and then clears.
- R9: While rst is high, grp_vld, tx_allow, rx_ovf and rx_udf are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Oversampling clock for the decoder and the FIFO write side |
| clk_sys | input | 1 | System clock for the link side |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| rx_a | input | 1 | Received encoded data (A pair) |
| rx_b | input | 1 | Received encoded strobe (B pair) |
| port_ok | input | 1 | Port enabled, connected and not suspended |
| port_rcv | input | 1 | Port is in its receiving state |
| pwr_down | input | 1 | Power-down request |
| speed | input | 2 | Speed code selecting group width; held stable while the gate is open |
| grp_data | output | 8 | Delivered group, LSB-justified |
| grp_vld | output | 1 | One-cycle strobe marking a delivered group |
| tx_allow | output | 1 | Transmitter permit for this port |
| rx_ovf | output | 1 | Sticky FIFO overflow flag (clk_fast domain) |
| rx_udf | output | 1 | Sticky stream-stall flag (clk_sys domain) |

## Verification
The bench drives encoded streams for every speed code with bit periods that vary from 3 to 5 fast cycles. It rebuilds each expected group arithmetically, so a design that misplaces the first bit or mis-sizes a group shows up as a wrong value or a wrong group count. Partial groups are left dangling before the gate closes. A design that keeps the leftover bits then misaligns the next reception's first group. A design that leaks bits while the gate is shut delivers groups it must not deliver. One burst with a bit on every fast cycle overruns the FIFO: a design that overwrites stored entries corrupts the first eight groups, and one that ignores the full state never raises the overflow flag. The bench also checks that the stall flag stays low during normal pacing and rises only after a real stall.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'd0,
    SPD_MID  = 2'd1,
    SPD_HIGH = 2'd2,
    SPD_RSV  = 2'd3
  } spd_e;

  // bits per delivered group for a speed code
  function automatic logic [3:0] grp_len(input logic [1:0] sp);
    case (spd_e'(sp))
      SPD_LOW: grp_len = 4'd2;
      SPD_MID: grp_len = 4'd4;
      default: grp_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/ds_bit_detect.sv
module ds_bit_detect (
  input  logic clk,
  input  logic rst,
  input  logic rx_on,
  input  logic in_a,
  input  logic in_b,
  output logic bit_vld,
  output logic bit_val
);
  logic a_s1, a_s2, b_s1, b_s2;
  logic x_prev, en_prev;
  logic x_now;

  assign x_now = a_s2 ^ b_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_s1 <= 1'b0; a_s2 <= 1'b0;
      b_s1 <= 1'b0; b_s2 <= 1'b0;
      x_prev  <= 1'b0;
      en_prev <= 1'b0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      a_s1 <= in_a; a_s2 <= a_s1;
      b_s1 <= in_b; b_s2 <= b_s1;
      x_prev  <= x_now;
      en_prev <= rx_on;
      // first enabled cycle only takes a baseline of the line state
      bit_vld <= rx_on && en_prev && (x_now != x_prev);
      bit_val <= a_s2;
    end
  end
endmodule

// File: rtl/ds_group_pack.sv
module ds_group_pack import ds_rx_pkg::*; #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_on,
  input  logic [1:0]       speed,
  input  logic             bit_vld,
  input  logic             bit_val,
  output logic             push,
  output logic [GRP_W-1:0] word
);
  localparam int CW = $clog2(GRP_W + 1);

  logic [GRP_W-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    tgt;
  logic [GRP_W-1:0] sh_next;

  assign tgt     = CW'(grp_len(speed));
  assign sh_next = {shreg[GRP_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      push  <= 1'b0;
      word  <= '0;
    end else begin
      push <= 1'b0;
      if (!rx_on) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (bit_vld) begin
        if (cnt + CW'(1) == tgt) begin
          push  <= 1'b1;
          word  <= sh_next;
          shreg <= '0;
          cnt   <= '0;
        end else begin
          shreg <= sh_next;
          cnt   <= cnt + CW'(1);
        end
      end
    end
  end

  // R2: the fill count never reaches the selected group length
  a_r2_count_below_len: assert property (@(posedge clk) disable iff (rst)
    cnt < tgt);

endmodule

// File: rtl/ds_async_fifo.sv
module ds_async_fifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          ovf,
  input  logic          rclk,
  input  logic          rrst,
  output logic [DW-1:0] rdata,
  output logic          rvld
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    b2g = b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    g2b = b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, rg_s1, rg_s2;
  logic [AW:0] rbin, rgray, wg_s1, wg_s2;
  logic        full, empty;

  // write side
  assign full = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});

  always_ff @(posedge wclk) begin
    if (push && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      ovf   <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      ovf   <= push && full;
      if (push && !full) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  // read side
  assign empty = (rgray == wg_s2);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rvld  <= 1'b0;
      rdata <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rvld  <= !empty;
      if (!empty) begin
        rdata <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end
    end
  end

  // R7: the writer never believes more than DEPTH entries are stored
  logic [AW:0] w_level;
  assign w_level = wbin - g2b(rg_s2);
  a_r7_level_bound: assert property (@(posedge wclk) disable iff (wrst)
    w_level <= (AW+1)'(DEPTH));

endmodule

// File: rtl/ds_rx_resync.sv
module ds_rx_resync import ds_rx_pkg::*; #(
  parameter int GRP_W   = 8,
  parameter int FIFO_AW = 3,
  parameter int GAP_MAX = 32
) (
  input  logic             clk_fast,
  input  logic             clk_sys,
  input  logic             rst,
  input  logic             rx_a,
  input  logic             rx_b,
  input  logic             port_ok,
  input  logic             port_rcv,
  input  logic             pwr_down,
  input  logic [1:0]       speed,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_vld,
  output logic             tx_allow,
  output logic             rx_ovf,
  output logic             rx_udf
);
  localparam int GAP_CW = $clog2(GAP_MAX + 1);

  logic gate_raw;
  assign gate_raw = port_ok & port_rcv & ~pwr_down;

  // ---------------- fast domain ----------------
  logic [1:0] gate_f;
  logic [1:0] spd_f1, spd_f2;
  logic       rx_on_f;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      gate_f <= '0;
      spd_f1 <= '0;
      spd_f2 <= '0;
    end else begin
      gate_f <= {gate_f[0], gate_raw};
      spd_f1 <= speed;
      spd_f2 <= spd_f1;
    end
  end
  assign rx_on_f = gate_f[1];

  logic             bv, bval;
  logic             pk_push;
  logic [GRP_W-1:0] pk_word;
  logic             fifo_ovf;

  ds_bit_detect u_det (
    .clk(clk_fast), .rst(rst), .rx_on(rx_on_f),
    .in_a(rx_a), .in_b(rx_b), .bit_vld(bv), .bit_val(bval)
  );

  ds_group_pack #(.GRP_W(GRP_W)) u_pack (
    .clk(clk_fast), .rst(rst), .rx_on(rx_on_f), .speed(spd_f2),
    .bit_vld(bv), .bit_val(bval), .push(pk_push), .word(pk_word)
  );

  ds_async_fifo #(.DW(GRP_W), .AW(FIFO_AW)) u_fifo (
    .wclk(clk_fast), .wrst(rst), .push(pk_push), .wdata(pk_word), .ovf(fifo_ovf),
    .rclk(clk_sys), .rrst(rst), .rdata(grp_data), .rvld(grp_vld)
  );

  always_ff @(posedge clk_fast) begin
    if (rst || !rx_on_f) rx_ovf <= 1'b0;
    else if (fifo_ovf)   rx_ovf <= 1'b1;
  end

  // R4: no group is formed unless the gate was open the cycle before
  a_r4_no_push_when_closed: assert property (@(posedge clk_fast) disable iff (rst)
    !$past(rx_on_f) |-> !pk_push);

  // ---------------- system domain ----------------
  logic [2:0]        ctl_s1, ctl_s2;
  logic              rx_on_s;
  logic              started;
  logic [GAP_CW-1:0] gap;

  always_ff @(posedge clk_sys) begin
    if (rst) begin
      ctl_s1   <= '0;
      ctl_s2   <= '0;
      tx_allow <= 1'b0;
    end else begin
      ctl_s1   <= {port_ok, port_rcv, pwr_down};
      ctl_s2   <= ctl_s1;
      tx_allow <= ctl_s2[2] & ~ctl_s2[1] & ~ctl_s2[0];
    end
  end
  assign rx_on_s = ctl_s2[2] & ctl_s2[1] & ~ctl_s2[0];

  always_ff @(posedge clk_sys) begin
    if (rst || !rx_on_s) begin
      started <= 1'b0;
      gap     <= '0;
      rx_udf  <= 1'b0;
    end else if (grp_vld) begin
      started <= 1'b1;
      gap     <= '0;
    end else if (started) begin
      if (gap == GAP_CW'(GAP_MAX - 1)) rx_udf <= 1'b1;
      else                             gap    <= gap + 1'b1;
    end
  end

  // R8: the stall flag holds while the gate remains open
  a_r8_udf_sticky: assert property (@(posedge clk_sys) disable iff (rst)
    (rx_udf && rx_on_s) |=> rx_udf);

  // R6: transmit permit and an open receive gate never coexist
  a_r6_tx_rx_exclusive: assert property (@(posedge clk_sys) disable iff (rst)
    !(tx_allow && rx_on_s && $past(rx_on_s)));

endmodule

// File: tb/ds_rx_resync_test.sv
`timescale 1ns/1ps
module ds_rx_resync_test;
  logic clk_fast = 1'b0, clk_sys = 1'b0, rst = 1'b1;
  logic rx_a = 1'b0, rx_b = 1'b0;
  logic port_ok = 1'b0, port_rcv = 1'b0, pwr_down = 1'b0;
  logic [1:0] speed = 2'd0;
  logic [7:0] grp_data;
  logic grp_vld, tx_allow, rx_ovf, rx_udf;

  always #1.25 clk_fast = ~clk_fast;
  always #5    clk_sys  = ~clk_sys;

  ds_rx_resync uut (
    .clk_fast(clk_fast), .clk_sys(clk_sys), .rst(rst),
    .rx_a(rx_a), .rx_b(rx_b), .port_ok(port_ok), .port_rcv(port_rcv),
    .pwr_down(pwr_down), .speed(speed), .grp_data(grp_data),
    .grp_vld(grp_vld), .tx_allow(tx_allow), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
  );

  int total = 0, bad = 0;
  int mon_cnt = 0;
  logic [7:0] rx_buf [1024];

  always @(negedge clk_sys) begin
    if (!rst && grp_vld) begin
      if (mon_cnt < 1024) rx_buf[mon_cnt] = grp_data;
      mon_cnt = mon_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pb(input int seed, input int k);
    return ((k*k*3 + seed*k*5 + seed + (k >> 2)) >> 1) & 1;
  endfunction

  function automatic int wid(input int sp);
    return (sp == 0) ? 2 : (sp == 1) ? 4 : 8;
  endfunction

  function automatic int exp_grp(input int seed, input int g, input int w);
    int v = 0;
    for (int j = 0; j < w; j++) v |= pb(seed, g*w + j) << (w - 1 - j);
    return v;
  endfunction

  // data-strobe encoder: strobe flips when data repeats
  task automatic send_bit(input int b, input int n);
    @(negedge clk_fast);
    if (b[0] == rx_a) rx_b = ~rx_b;
    rx_a = b[0];
    repeat (n - 1) @(negedge clk_fast);
  endtask

  task automatic open_gate();
    port_ok = 1'b1; port_rcv = 1'b1; pwr_down = 1'b0;
    repeat (10) @(negedge clk_sys);
  endtask

  task automatic close_gate();
    repeat (20) @(negedge clk_fast);
    port_rcv = 1'b0;
    repeat (10) @(negedge clk_sys);
  endtask

  task automatic run_stream(input int sp, input int seed, input bit reopen);
    int w = wid(sp);
    int base;
    speed = sp[1:0];
    open_gate();
    base = mon_cnt;
    for (int k = 0; k < 12*w; k++) send_bit(pb(seed, k), 3 + ((k*5 + seed) % 3));
    repeat (15) @(negedge clk_sys);
    chk(mon_cnt - base == 12, "R3 group count", mon_cnt - base, 12);
    for (int g = 0; g < 12; g++)
      chk(int'(rx_buf[base + g]) == exp_grp(seed, g, w), "R1 R2 group value",
          rx_buf[base + g], exp_grp(seed, g, w));
    chk(rx_udf == 1'b0, "R8 no stall during stream", rx_udf, 0);
    repeat (45) @(negedge clk_sys);
    chk(rx_udf == 1'b1, "R8 stall flagged", rx_udf, 1);
    chk(rx_ovf == 1'b0, "R7 no overflow at normal pace", rx_ovf, 0);
    base = mon_cnt;
    for (int k = 0; k < w - 1; k++) send_bit(pb(seed + 100, k), 4);
    close_gate();
    chk(mon_cnt == base, "R5 partial discarded", mon_cnt - base, 0);
    chk(rx_udf == 1'b0, "R8 cleared on close", rx_udf, 0);
    if (reopen) begin
      open_gate();
      base = mon_cnt;
      for (int k = 0; k < w; k++) send_bit(pb(seed + 50, k), 4);
      repeat (20) @(negedge clk_sys);
      chk(mon_cnt - base == 1, "R5 fresh group count", mon_cnt - base, 1);
      chk(int'(rx_buf[base]) == exp_grp(seed + 50, 0, w), "R5 fresh group value",
          rx_buf[base], exp_grp(seed + 50, 0, w));
      close_gate();
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (8) @(negedge clk_sys);
    // R9 reset state
    chk(grp_vld == 1'b0, "R9 grp_vld in reset", grp_vld, 0);
    chk(tx_allow == 1'b0, "R9 tx_allow in reset", tx_allow, 0);
    chk(rx_ovf == 1'b0, "R9 rx_ovf in reset", rx_ovf, 0);
    chk(rx_udf == 1'b0, "R9 rx_udf in reset", rx_udf, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk_sys);

    // R6 all control combinations
    for (int c = 0; c < 8; c++) begin
      port_ok = c[2]; port_rcv = c[1]; pwr_down = c[0];
      repeat (5) @(negedge clk_sys);
      chk(tx_allow == (c[2] & ~c[1] & ~c[0]), "R6 tx_allow", tx_allow,
          c[2] & ~c[1] & ~c[0]);
    end
    port_ok = 1'b0; port_rcv = 1'b0; pwr_down = 1'b0;
    repeat (5) @(negedge clk_sys);

    // R2 R3 every speed code, several bit patterns
    for (int sp = 0; sp < 4; sp++)
      for (int seed = 0; seed < 3; seed++)
        run_stream(sp, seed, seed == 2);

    // R4 closed gate variants
    for (int v = 0; v < 3; v++) begin
      speed = 2'd0;
      port_ok = (v != 0); port_rcv = (v != 1); pwr_down = (v == 2);
      repeat (10) @(negedge clk_sys);
      base = mon_cnt;
      for (int k = 0; k < 24; k++) send_bit(pb(v, k), 3);
      repeat (30) @(negedge clk_sys);
      chk(mon_cnt == base, "R4 no groups while closed", mon_cnt - base, 0);
    end
    port_ok = 1'b0; port_rcv = 1'b0; pwr_down = 1'b0;
    repeat (10) @(negedge clk_sys);

    // R7 overflow burst: one bit per fast cycle at 2-bit groups
    speed = 2'd0;
    open_gate();
    base = mon_cnt;
    for (int k = 0; k < 64; k++) send_bit(pb(7, k), 1);
    repeat (100) @(negedge clk_sys);
    chk(rx_ovf == 1'b1, "R7 overflow flagged", rx_ovf, 1);
    chk(mon_cnt - base < 32, "R7 groups dropped", mon_cnt - base, 31);
    chk(mon_cnt - base >= 8, "R7 stored groups kept", mon_cnt - base, 8);
    for (int g = 0; g < 8; g++)
      chk(int'(rx_buf[base + g]) == exp_grp(7, g, 2), "R7 stored group value",
          rx_buf[base + g], exp_grp(7, g, 2));
    close_gate();
    repeat (4) @(negedge clk_sys);
    chk(rx_ovf == 1'b0, "R7 overflow cleared on close", rx_ovf, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule